// File: doc/BRIEF.md
# Configuration Port Word Feeder

This block moves a run of configuration words from a valid/ready stream source into an on-chip configuration-memory write port. The port has a chip-enable, a write strobe, a data bus and a busy output. The feeder raises chip-enable and write together whenever it holds a word for the port. While busy is high it keeps that word on the bus. When busy falls the transfer resumes, so no word is dropped and none is sent twice.

Software or a sequencer programs three things and then pulses start: the number of words, the data mode and a busy timeout. In the 32-bit mode the port takes one full word per clock. In the 8-bit mode each word is split into four bytes, sent most significant byte first. The block counts the words delivered and the cycles lost to busy back-pressure. With these two counts the total reconfiguration time can be split into its feed component and its busy component. After the last word the block pulses done. It also raises a sticky error flag when busy holds a word back for longer than the programmed limit.

Top module: `cfg_word_feeder`

## Requirements
- R1: While reset is asserted and after it is released, portCe, portWr, inReady, done and timeoutErr are low, and wordsSent and stallCycles are zero.
- R2: A start pulse samples wordTotal, byteMode and busyLimit, clears wordsSent, stallCycles and timeoutErr, and drops any word held from an earlier run. With a nonzero count, inReady rises in the cycle after start.
- R3: portCe and portWr are always equal. They are high exactly on the cycles where a word is presented. A beat counts as accepted on a cycle where both are high and portBusy is low.
- R4: While portBusy is high and a word is presented, portData stays stable and chip-enable stays high. The sequence of accepted beats matches the source words in order, with none lost or repeated, including when the source leaves gaps.
- R5: In the 32-bit mode (byteMode = 0), a valid source and a port that is never busy give one accepted word per clock. Done appears 3 + (B-1)(g+1) cycles after the start cycle, where B is the number of beats and the port stays busy for g cycles after each accepted beat.
- R6: In the 8-bit mode (byteMode = 1), each word is sent as four beats on portData[7:0], with portData[31:8] zero. The first beat is bits 31:24 and the last is bits 7:0. The mode is taken at start, and changing byteMode during a run has no effect.
- R7: wordsSent counts the whole words delivered to the port. At the end of a run it equals the programmed count.
- R8: stallCycles counts the cycles on which a word is presented while portBusy is high. Busy cycles with no word presented are not counted.
- R9: done is a single-cycle pulse in the cycle after the last word is accepted. Chip-enable and inReady are low from then on. A start with a count of zero gives done in the next cycle and never raises inReady.
- R10: timeoutErr rises in the cycle after the (busyLimit+1)-th consecutive stalled cycle. It stays high until the next start. A run of exactly busyLimit stalled cycles does not raise it.
- R11: A start during a run aborts that run at once. The new run begins again from its first source word, and the aborted run never produces done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the configuration port |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that programs and starts a run |
| wordTotal | input | 16 | Number of words in the run, sampled at start |
| byteMode | input | 1 | 1 selects the 8-bit mode, 0 the 32-bit mode, sampled at start |
| busyLimit | input | 12 | Longest allowed stall in cycles, sampled at start |
| inValid | input | 1 | Source has a word on inData |
| inData | input | 32 | Source configuration word |
| inReady | output | 1 | Feeder takes the source word this cycle |
| portCe | output | 1 | Configuration port chip-enable |
| portWr | output | 1 | Configuration port write strobe |
| portData | output | 32 | Configuration port data input |
| portBusy | input | 1 | Configuration port cannot accept data |
| done | output | 1 | One-cycle pulse after the last word is accepted |
| timeoutErr | output | 1 | Sticky flag for a stall longer than busyLimit |
| wordsSent | output | 16 | Words delivered in the current or last run |
| stallCycles | output | 24 | Cycles stalled on busy in the current or last run |

## Verification
On every cycle, the assertions check the following: the presented data and chip-enable stay unchanged across a busy cycle; the source is never drained while a word is stuck behind busy; done is a lone pulse with the port idle; the word and stall counters step by exactly one on their strobes; and the timeout flag stays set until the next start. The bench scenarios are needed for the rest: the byte order in the 8-bit mode, the order of the delivered words and the absence of duplicates against the source, the exact cycle of done for a given busy pattern, the final counter values, the boundary between a stall of exactly busyLimit and one cycle longer, and the abort-and-restart behaviour.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

  localparam int WORD_W     = 32;
  localparam int LANE_W     = 8;
  localparam int LANES      = WORD_W / LANE_W;
  localparam int LANE_IDX_W = $clog2(LANES);

  // Strobes from control to datapath, valid in the cycle they are raised.
  typedef struct packed {
    logic                  clear;     // start of a run: wipe counters
    logic                  load;      // capture the source word
    logic                  wordOk;    // last beat of the held word accepted
    logic                  stall;     // word presented while port is busy
    logic                  byteMode;  // latched mode of the current run
    logic [LANE_IDX_W-1:0] lane;      // byte beat index, 0 = most significant
  } feedStrobeT;

endpackage

// File: rtl/feeder_ctrl.sv
module feeder_ctrl
  import feeder_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordTotal,
  input  logic             byteMode,
  input  logic             inValid,
  input  logic             portBusy,
  output logic             inReady,
  output logic             portCe,
  output logic             portWr,
  output logic             done,
  output feedStrobeT       strb
);

  localparam logic [LANE_IDX_W-1:0] LAST_LANE = LANE_IDX_W'(LANES - 1);

  logic                  running;
  logic                  holdValid;
  logic                  modeByte;
  logic                  doneQ;
  logic [CNT_W-1:0]      fetchLeft;
  logic [CNT_W-1:0]      sentLeft;
  logic [LANE_IDX_W-1:0] laneIdx;

  logic lastLane;
  logic beatOk;
  logic wordOk;
  logic take;

  always_comb begin
    lastLane = !modeByte || (laneIdx == LAST_LANE);
    beatOk   = holdValid && !portBusy;
    wordOk   = beatOk && lastLane;
    // Refill in the same cycle the held word leaves, so the port sees no gap.
    inReady  = !start && running && (fetchLeft != '0) && (!holdValid || wordOk);
    take     = inReady && inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      holdValid <= 1'b0;
      modeByte  <= 1'b0;
      doneQ     <= 1'b0;
      fetchLeft <= '0;
      sentLeft  <= '0;
      laneIdx   <= '0;
    end else if (start) begin
      running   <= (wordTotal != '0);
      holdValid <= 1'b0;
      modeByte  <= byteMode;
      doneQ     <= (wordTotal == '0);
      fetchLeft <= wordTotal;
      sentLeft  <= wordTotal;
      laneIdx   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (take) begin
        fetchLeft <= fetchLeft - CNT_W'(1);
      end
      if (take) begin
        holdValid <= 1'b1;
      end else if (wordOk) begin
        holdValid <= 1'b0;
      end
      if (take || wordOk) begin
        laneIdx <= '0;
      end else if (beatOk) begin
        laneIdx <= laneIdx + LANE_IDX_W'(1);
      end
      if (wordOk) begin
        sentLeft <= sentLeft - CNT_W'(1);
        if (sentLeft == CNT_W'(1)) begin
          doneQ   <= 1'b1;
          running <= 1'b0;
        end
      end
    end
  end

  assign portCe = holdValid;
  assign portWr = holdValid;
  assign done   = doneQ;

  always_comb begin
    strb.clear    = start;
    strb.load     = take;
    strb.wordOk   = wordOk && !start;
    strb.stall    = holdValid && portBusy && !start;
    strb.byteMode = modeByte;
    strb.lane     = laneIdx;
  end

  // R4: the source is never drained while the held word is stuck behind busy
  assert_no_drain_on_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!portCe || !portBusy));

  // R9: done is a single pulse unless a new start asked for another
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done || $past(start)));

  // R9: nothing is presented or fetched once done is signalled
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!portCe && !inReady));

endmodule

// File: rtl/feeder_dp.sv
module feeder_dp
  import feeder_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STALL_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  feedStrobeT         strb,
  input  logic [WORD_W-1:0]  inData,
  output logic [WORD_W-1:0]  portData,
  output logic [CNT_W-1:0]   wordsSent,
  output logic [STALL_W-1:0] stallCycles
);

  logic [WORD_W-1:0] holdReg;
  logic [LANE_W-1:0] lanes [LANES];

  // Lane 0 is the most significant byte, so beats go out high byte first.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign lanes[g] = holdReg[WORD_W-1-g*LANE_W -: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strb.load) begin
      holdReg <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordsSent   <= '0;
      stallCycles <= '0;
    end else if (strb.clear) begin
      wordsSent   <= '0;
      stallCycles <= '0;
    end else begin
      if (strb.wordOk) begin
        wordsSent <= wordsSent + CNT_W'(1);
      end
      if (strb.stall) begin
        stallCycles <= stallCycles + STALL_W'(1);
      end
    end
  end

  always_comb begin
    if (strb.byteMode) begin
      portData = {{(WORD_W-LANE_W){1'b0}}, lanes[strb.lane]};
    end else begin
      portData = holdReg;
    end
  end

  // R7: one completed word adds exactly one to the delivered count
  assert_word_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wordOk && !strb.clear) |=> (wordsSent == $past(wordsSent) + CNT_W'(1)));

  // R8: each stalled cycle adds exactly one to the stall count
  assert_stall_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stall && !strb.clear) |=> (stallCycles == $past(stallCycles) + STALL_W'(1)));

  // R8: a cycle without stall leaves the stall count alone
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stall && !strb.clear) |=> $stable(stallCycles));

endmodule

// File: rtl/feeder_stallmon.sv
module feeder_stallmon #(
  parameter int TO_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            clear,
  input  logic            stall,
  input  logic [TO_W-1:0] busyLimit,
  output logic            timeoutErr
);

  logic [TO_W-1:0] limitReg;
  logic [TO_W-1:0] runCnt;
  logic            errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReg <= '0;
      runCnt   <= '0;
      errQ     <= 1'b0;
    end else if (clear) begin
      limitReg <= busyLimit;
      runCnt   <= '0;
      errQ     <= 1'b0;
    end else if (stall) begin
      // runCnt holds the earlier stalled cycles of this run of stalls
      if (runCnt >= limitReg) begin
        errQ <= 1'b1;
      end
      if (runCnt != '1) begin
        runCnt <= runCnt + TO_W'(1);
      end
    end else begin
      runCnt <= '0;
    end
  end

  assign timeoutErr = errQ;

  // R10: the timeout flag is sticky until the next start
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !clear) |=> timeoutErr);

  // R10: the flag only rises after a stalled cycle
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(stall));

endmodule

// File: rtl/cfg_word_feeder.sv
module cfg_word_feeder
  import feeder_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STALL_W = 24,
  parameter int TO_W    = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   wordTotal,
  input  logic               byteMode,
  input  logic [TO_W-1:0]    busyLimit,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  inData,
  output logic               inReady,
  output logic               portCe,
  output logic               portWr,
  output logic [WORD_W-1:0]  portData,
  input  logic               portBusy,
  output logic               done,
  output logic               timeoutErr,
  output logic [CNT_W-1:0]   wordsSent,
  output logic [STALL_W-1:0] stallCycles
);

  feedStrobeT strb;

  feeder_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wordTotal (wordTotal),
    .byteMode  (byteMode),
    .inValid   (inValid),
    .portBusy  (portBusy),
    .inReady   (inReady),
    .portCe    (portCe),
    .portWr    (portWr),
    .done      (done),
    .strb      (strb)
  );

  feeder_dp #(.CNT_W(CNT_W), .STALL_W(STALL_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .inData      (inData),
    .portData    (portData),
    .wordsSent   (wordsSent),
    .stallCycles (stallCycles)
  );

  feeder_stallmon #(.TO_W(TO_W)) uMon (
    .clk        (clk),
    .rstN       (rstN),
    .clear      (strb.clear),
    .stall      (strb.stall),
    .busyLimit  (busyLimit),
    .timeoutErr (timeoutErr)
  );

  // R4: a word stuck behind busy stays on the bus unchanged
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (portCe && portBusy && !start) |=> (portCe && $stable(portData)));

  // R3: chip-enable and write always move together
  assert_ce_wr_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    portCe == portWr);

endmodule

// File: tb/cfg_word_feeder_test.sv
module cfg_word_feeder_test;

  localparam int CNT_W   = 16;
  localparam int STALL_W = 24;
  localparam int TO_W    = 12;

  typedef struct packed {
    logic        mode;
    logic [7:0]  count;
    logic [3:0]  gap;
    logic [7:0]  limit;
    logic [15:0] stall;
    logic        err;
  } vecT;

  // mode, words, busy gap after each beat, busy limit, expected stalls, expected error
  localparam vecT VECS [8] = '{
    '{1'b0, 8'd8, 4'd0, 8'd5, 16'd0,  1'b0},
    '{1'b0, 8'd5, 4'd2, 8'd4, 16'd8,  1'b0},
    '{1'b1, 8'd3, 4'd0, 8'd3, 16'd0,  1'b0},
    '{1'b1, 8'd2, 4'd1, 8'd0, 16'd7,  1'b1},
    '{1'b0, 8'd1, 4'd3, 8'd2, 16'd0,  1'b0},
    '{1'b0, 8'd4, 4'd3, 8'd3, 16'd9,  1'b0},
    '{1'b0, 8'd4, 4'd4, 8'd3, 16'd12, 1'b1},
    '{1'b1, 8'd1, 4'd2, 8'd7, 16'd6,  1'b0}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic [CNT_W-1:0]   wordTotal = '0;
  logic               byteMode = 1'b0;
  logic [TO_W-1:0]    busyLimit = '0;
  logic               inValid;
  logic [31:0]        inData;
  logic               inReady;
  logic               portCe;
  logic               portWr;
  logic [31:0]        portData;
  logic               portBusy;
  logic               done;
  logic               timeoutErr;
  logic [CNT_W-1:0]   wordsSent;
  logic [STALL_W-1:0] stallCycles;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cfg_word_feeder #(.CNT_W(CNT_W), .STALL_W(STALL_W), .TO_W(TO_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .wordTotal(wordTotal),
    .byteMode(byteMode), .busyLimit(busyLimit), .inValid(inValid),
    .inData(inData), .inReady(inReady), .portCe(portCe), .portWr(portWr),
    .portData(portData), .portBusy(portBusy), .done(done),
    .timeoutErr(timeoutErr), .wordsSent(wordsSent), .stallCycles(stallCycles)
  );

  function automatic logic [31:0] wordOf(input int i);
    return 32'h5A3C_0F00 ^ (32'(i) * 32'h0101_0107);
  endfunction

  function automatic logic [31:0] expBeat(input int k, input bit b);
    logic [31:0] w;
    int sh;
    if (!b) return wordOf(k);
    w  = wordOf(k / 4);
    sh = 3 - (k % 4);
    return {24'h0, w[sh*8 +: 8]};
  endfunction

  // Port model: busy for gapCfg cycles after every accepted beat.
  int gapCfg = 0;
  int gapCnt = 0;
  assign portBusy = (gapCnt != 0);
  always @(posedge clk) begin
    if (start) gapCnt <= 0;
    else if (portCe && portWr && !portBusy) gapCnt <= gapCfg;
    else if (gapCnt != 0) gapCnt <= gapCnt - 1;
  end

  // Source model: words wordOf(0..srcCount-1), optionally every other cycle.
  int srcIdx = 0;
  int srcCount = 0;
  bit srcThrottle = 1'b0;
  bit phase = 1'b0;
  assign inValid = (srcIdx < srcCount) && (!srcThrottle || phase);
  assign inData  = wordOf(srcIdx);
  always @(posedge clk) begin
    phase <= ~phase;
    if (start) srcIdx <= 0;
    else if (inValid && inReady) srcIdx <= srcIdx + 1;
  end

  // Monitor sampled at the falling edge.
  bit monByte = 1'b0;
  int beats = 0, badBeats = 0, doneCount = 0, doneAt = -1, cyc = 0;
  int ceAfterDone = 0, ceWrMismatch = 0, readySeen = 0;
  logic [31:0] firstAct = '0, firstExp = '0;
  always @(negedge clk) begin
    if (start) begin
      beats = 0; badBeats = 0; doneCount = 0; doneAt = -1; cyc = 0;
      ceAfterDone = 0; ceWrMismatch = 0; readySeen = 0;
    end else begin
      cyc++;
      if (portCe !== portWr) ceWrMismatch++;
      if (portCe && doneCount > 0) ceAfterDone++;
      if (inReady) readySeen++;
      if (portCe && portWr && !portBusy) begin
        if (portData !== expBeat(beats, monByte)) begin
          if (badBeats == 0) begin
            firstAct = portData;
            firstExp = expBeat(beats, monByte);
          end
          badBeats++;
        end
        beats++;
      end
      if (done) begin
        doneCount++;
        if (doneAt < 0) doneAt = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCase(input bit mode, input int count, input int gap, input int limit,
                         input int expStall, input bit expErr, input bit throttle,
                         input bit flip, input string tag);
    int nBeats;
    int expDone;
    nBeats  = mode ? 4 * count : count;
    expDone = (nBeats == 0) ? 1 : 3 + (nBeats - 1) * (gap + 1);
    @(posedge clk); #1;
    byteMode    = mode;
    wordTotal   = CNT_W'(count);
    busyLimit   = TO_W'(limit);
    gapCfg      = gap;
    srcCount    = count;
    srcThrottle = throttle;
    monByte     = mode;
    start       = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (flip) byteMode = ~mode;
    for (int i = 0; i < 3000 && doneCount == 0; i++) begin
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    #1;
    $display("[TB] case %s", tag);
    chk(doneCount == 1, "R9", "done pulses", doneCount, 1);
    chk(ceAfterDone == 0, "R9", "chip-enable cycles after done", ceAfterDone, 0);
    chk(ceWrMismatch == 0, "R3", "ce/wr mismatch cycles", ceWrMismatch, 0);
    chk(beats == nBeats, "R4", "accepted beats", beats, nBeats);
    if (mode)
      chk(badBeats == 0, "R6", "byte beat value", firstAct, firstExp);
    else
      chk(badBeats == 0, "R4", "word beat value", firstAct, firstExp);
    chk(int'(wordsSent) == count, "R7", "wordsSent", wordsSent, count);
    if (!throttle)
      chk(int'(stallCycles) == expStall, "R8", "stallCycles", stallCycles, expStall);
    chk(timeoutErr == expErr, "R10", "timeoutErr", timeoutErr, expErr);
    if (!throttle)
      chk(doneAt == expDone, "R5", "done cycle", doneAt, expDone);
    if (count == 0)
      chk(readySeen == 0, "R9", "inReady cycles for empty run", readySeen, 0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!portCe && !portWr, "R1", "chip-enable in reset", portCe, 0);
    chk(!inReady, "R1", "inReady in reset", inReady, 0);
    chk(!done && !timeoutErr, "R1", "done/error in reset", {done, timeoutErr}, 0);
    chk(wordsSent == 0 && stallCycles == 0, "R1", "counters in reset", wordsSent + stallCycles, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!portCe && !inReady && !done, "R1", "idle after reset", {portCe, inReady, done}, 0);

    // Table-driven runs: R5, R6, R7, R8, R10
    for (int v = 0; v < 8; v++) begin
      runCase(VECS[v].mode, int'(VECS[v].count), int'(VECS[v].gap), int'(VECS[v].limit),
              int'(VECS[v].stall), VECS[v].err, 1'b0, 1'b0, $sformatf("vector %0d", v));
    end

    // R9: empty run
    runCase(1'b0, 0, 0, 3, 0, 1'b0, 1'b0, 1'b0, "zero count");

    // R4: source leaves gaps, order must survive
    runCase(1'b0, 6, 0, 3, 0, 1'b0, 1'b1, 1'b0, "throttled source");
    runCase(1'b1, 2, 2, 9, 0, 1'b0, 1'b1, 1'b0, "throttled bytes");

    // R6: mode input changed mid-run must have no effect
    runCase(1'b1, 2, 1, 9, 7, 1'b0, 1'b0, 1'b1, "mode flipped mid-run");

    // R2: inReady rises the cycle after start
    @(posedge clk); #1;
    byteMode = 1'b0; wordTotal = 16'd2; busyLimit = 12'd5; gapCfg = 0;
    srcCount = 0; srcThrottle = 1'b0; monByte = 1'b0; start = 1'b1;
    @(negedge clk);
    chk(!inReady, "R2", "inReady during start cycle", inReady, 0);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(inReady, "R2", "inReady after start", inReady, 1);
    chk(wordsSent == 0 && stallCycles == 0, "R2", "counters cleared", wordsSent + stallCycles, 0);

    // R11: abort a run that already flagged a timeout
    @(posedge clk); #1;
    byteMode = 1'b0; wordTotal = 16'd10; busyLimit = 12'd0; gapCfg = 2;
    srcCount = 10; monByte = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(timeoutErr, "R10", "error after first over-limit stall", timeoutErr, 1);
    chk(portCe && portBusy, "R4", "word held under busy", {portCe, portBusy}, 3);
    runCase(1'b0, 3, 0, 5, 0, 1'b0, 1'b0, 1'b0, "R11 restart after abort");
    chk(stallCycles == 0, "R2", "stall count cleared by restart", stallCycles, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule